// File: doc/BRIEF.md
# Demagnetization Sense Sequencer

This block times the auxiliary-winding sense input of a quasi-resonant flyback controller around each power-switch off transition. When the driver turns the switch off, the block holds the sense node to ground for a short interval and ignores the zero-crossing comparator for a longer blanking interval. Both intervals are longer at high load than at low load. After blanking ends it follows the comparator. A falling crossing marks the core-reset valley and produces a valley-ready pulse after a fixed turn-on delay. If the input stops moving for too long, the block asks for a fresh switching cycle instead.

At the end of every blanking window the block also samples a second comparator that reports a sense level below the short threshold. It declares an auxiliary-winding or output short only when several such cycles occur back to back. All intervals are counted in cycles of a 100 MHz reference clock and set by parameters.

Top module: `demag_seq`

## Requirements
- R1: During and directly after reset, `sense_clamp`, `valley_ready`, `restart_req` and `short_fault` are all low.
- R2: A `drv_off` strobe starts a blanking window of 145 clock cycles when `high_load` is 1 and 75 cycles when it is 0. Edges on `zcd_high` inside the window neither produce a valley nor reset the timeout.
- R3: `sense_clamp` is high for the first 75 cycles of the window at high load and for the first 35 cycles at low load, starting the cycle after the strobe.
- R4: At the last cycle of blanking, `short_low` = 1 counts a short cycle. The fourth consecutive short cycle raises `short_fault` for one cycle, clears the run and returns the block to idle without watching for a valley.
- R5: A blanking end with `short_low` = 0 clears the consecutive-short run to zero.
- R6: After blanking, a high-to-low change of `zcd_high` (1 = sense above the crossing threshold) is a valley. `valley_ready` pulses for one cycle 29 cycles after the clock edge that sampled the fall.
- R7: While watching, any change of `zcd_high` restarts a 450-cycle timer. This timer also starts at the end of blanking. If it expires with no valley, `restart_req` pulses for one cycle.
- R8: A `drv_off` strobe in any phase aborts a pending valley or timeout and starts a new blanking window. The cycle after a strobe shows no pulse output.
- R9: The load level is captured at the strobe. Later changes of `high_load` do not alter that window's blanking or clamp length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_off | input | 1 | One-cycle strobe at the end of switch on-time |
| zcd_high | input | 1 | Zero-crossing comparator, 1 = sense above threshold |
| short_low | input | 1 | Short comparator, 1 = sense below short threshold |
| high_load | input | 1 | 1 = control level above the high-load point |
| sense_clamp | output | 1 | Hold the sense node to ground |
| valley_ready | output | 1 | One-cycle pulse: turn the switch on |
| restart_req | output | 1 | One-cycle pulse: demagnetization timeout |
| short_fault | output | 1 | One-cycle pulse: consecutive-short fault |

## Verification
The bench targets these cases:
- A comparator glitch inside blanking. A design that watched too early would fire a valley on it.
- The sense input falling during blanking and then staying still. The only correct result is a timeout, at blanking end plus 450 cycles.
- A rising edge late in the watch phase, which must push the timeout out. A timer that ran only from blanking end would restart early.
- Short runs of three, broken by a clean cycle and then resumed. A counter that is never cleared would declare a fault too soon.
- A new strobe arriving during a pending valley delay and during a load-level change. A wrong design would leak a stale pulse or use the wrong window length.

// File: rtl/dsense_pkg.sv
package dsense_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_WATCH = 2'd2,
        PH_DELAY = 2'd3
    } phase_e;
endpackage

// File: rtl/dsense_edge.sv
module dsense_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fell,
    output logic moved
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
        fell   = prev_q & ~level;
        moved  = prev_q ^ level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dsense_run.sv
module dsense_run #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic is_short,
    output logic fire
);
    localparam int RW = $clog2(RUN_LEN + 1);
    logic [RW-1:0] run_d, run_q;

    always_comb begin
        fire  = sample && is_short && (run_q == RW'(RUN_LEN - 1));
        run_d = run_q;
        if (sample) begin
            if (!is_short || fire) run_d = '0;
            else                   run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/demag_seq.sv
module demag_seq
    import dsense_pkg::*;
#(
    parameter int BLANK_HI   = 145,
    parameter int BLANK_LO   = 75,
    parameter int HOLD_HI    = 75,
    parameter int HOLD_LO    = 35,
    parameter int TOUT_CYC   = 450,
    parameter int VALLEY_DLY = 29,
    parameter int SHORT_RUN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_off,
    input  logic zcd_high,
    input  logic short_low,
    input  logic high_load,
    output logic sense_clamp,
    output logic valley_ready,
    output logic restart_req,
    output logic short_fault
);
    localparam int CW = $clog2(BLANK_HI + BLANK_LO + TOUT_CYC + VALLEY_DLY + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [CW-1:0] blen;
        logic [CW-1:0] hlen;
        logic          valley;
        logic          restart;
        logic          fault;
    } seq_t;

    seq_t st_d, st_q;
    logic zcd_fall, zcd_move, blank_end, run_fire;

    dsense_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (zcd_high),
        .fell  (zcd_fall),
        .moved (zcd_move)
    );

    assign blank_end = (st_q.ph == PH_BLANK) && (st_q.cnt == st_q.blen - 1'b1) && !drv_off;

    dsense_run #(.RUN_LEN(SHORT_RUN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (blank_end),
        .is_short (short_low),
        .fire     (run_fire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valley  = 1'b0;
        st_d.restart = 1'b0;
        st_d.fault   = 1'b0;
        if (drv_off) begin
            st_d.ph   = PH_BLANK;
            st_d.cnt  = '0;
            st_d.blen = high_load ? CW'(BLANK_HI) : CW'(BLANK_LO);
            st_d.hlen = high_load ? CW'(HOLD_HI)  : CW'(HOLD_LO);
        end else begin
            case (st_q.ph)
                PH_BLANK: begin
                    if (blank_end) begin
                        st_d.cnt = '0;
                        if (run_fire) begin
                            st_d.fault = 1'b1;
                            st_d.ph    = PH_IDLE;
                        end else begin
                            st_d.ph = PH_WATCH;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_WATCH: begin
                    if (zcd_fall) begin
                        st_d.ph  = PH_DELAY;
                        st_d.cnt = '0;
                    end else if (zcd_move) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == CW'(TOUT_CYC - 1)) begin
                        st_d.restart = 1'b1;
                        st_d.ph      = PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_DELAY: begin
                    if (st_q.cnt == CW'(VALLEY_DLY - 1)) begin
                        st_d.valley = 1'b1;
                        st_d.ph     = PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, blen: '0, hlen: '0,
                      valley: 1'b0, restart: 1'b0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sense_clamp  = (st_q.ph == PH_BLANK) && (st_q.cnt < st_q.hlen);
    assign valley_ready = st_q.valley;
    assign restart_req  = st_q.restart;
    assign short_fault  = st_q.fault;
endmodule

// File: rtl/demag_seq_chk.sv
module demag_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic drv_off,
    input logic zcd_high,
    input logic short_low,
    input logic high_load,
    input logic sense_clamp,
    input logic valley_ready,
    input logic restart_req,
    input logic short_fault
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valley_ready, restart_req, short_fault})); // R6

    AST_OFF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |=> sense_clamp); // R3

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |=> !(valley_ready || restart_req || short_fault)); // R8

    AST_CLAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sense_clamp |-> !(valley_ready || restart_req || short_fault)); // R2

    AST_VALLEY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valley_ready |=> !valley_ready); // R6

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R7

    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        short_fault |=> !short_fault); // R4
endmodule

bind demag_seq demag_seq_chk u_chk (.*);

// File: tb/tb_demag_seq.sv
module tb_demag_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv = 1'b0, z = 1'b0, sh = 1'b0, hi = 1'b0;
    logic clamp, valley, rstq, fault;

    int tests = 0, fails = 0, cycles = 0;
    int n_hold = 0, n_val = 0, n_rst = 0, n_flt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    demag_seq dut (
        .clk(clk), .rst_n(rst_n), .drv_off(drv), .zcd_high(z),
        .short_low(sh), .high_load(hi), .sense_clamp(clamp),
        .valley_ready(valley), .restart_req(rstq), .short_fault(fault)
    );

    // behavioural reference: phase 0 idle, 1 blanking, 2 watching, 3 delaying
    int  m_ph = 0, m_c = 0, m_bl = 0, m_hl = 0, m_run = 0;
    bit  m_prv = 0, m_v = 0, m_r = 0, m_f = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_c = 0; m_bl = 0; m_hl = 0; m_run = 0;
            m_prv = 0; m_v = 0; m_r = 0; m_f = 0;
        end else begin
            m_v = 0; m_r = 0; m_f = 0;
            if (drv) begin
                m_ph = 1; m_c = 0;
                m_bl = hi ? 145 : 75;
                m_hl = hi ? 75 : 35;
            end else if (m_ph == 1) begin
                if (m_c == m_bl - 1) begin
                    m_c = 0;
                    if (sh) begin
                        m_run++;
                        if (m_run == 4) begin m_run = 0; m_f = 1; m_ph = 0; end
                        else m_ph = 2;
                    end else begin
                        m_run = 0; m_ph = 2;
                    end
                end else m_c++;
            end else if (m_ph == 2) begin
                if (m_prv && !z) begin m_ph = 3; m_c = 0; end
                else if (m_prv != z) m_c = 0;
                else if (m_c == 449) begin m_r = 1; m_ph = 0; end
                else m_c++;
            end else if (m_ph == 3) begin
                if (m_c == 28) begin m_v = 1; m_ph = 0; end
                else m_c++;
            end
            m_prv = z;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit m_hold;
        @(negedge clk);
        m_hold = (m_ph == 1) && (m_c < m_hl);
        tests++;
        if (clamp !== m_hold || valley !== m_v || rstq !== m_r || fault !== m_f) begin
            fails++;
            if (clamp !== m_hold) $display("FAIL R3 clamp actual=%0b expected=%0b at %0t", clamp, m_hold, $time);
            if (valley !== m_v)   $display("FAIL R6 valley actual=%0b expected=%0b at %0t", valley, m_v, $time);
            if (rstq !== m_r)     $display("FAIL R7 restart actual=%0b expected=%0b at %0t", rstq, m_r, $time);
            if (fault !== m_f)    $display("FAIL R4 fault actual=%0b expected=%0b at %0t", fault, m_f, $time);
        end
        n_hold += int'(clamp);
        n_val  += int'(valley);
        n_rst  += int'(rstq);
        n_flt  += int'(fault);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic strobe();
        drv = 1'b1; tick(); drv = 1'b0;
    endtask

    task automatic zero();
        n_hold = 0; n_val = 0; n_rst = 0; n_flt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 clamp in reset", int'(clamp), 0);
        chk("R1 pulses in reset", int'(valley | rstq | fault), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 clamp after reset", int'(clamp), 0);

        // high load: glitch inside blanking, then a real valley
        zero(); hi = 1; z = 1; sh = 0;
        strobe(); run(19); z = 0; run(2); z = 1; run(150); z = 0; run(40);
        chk("R3 clamp length high load", n_hold, 75);
        chk("R2 glitch ignored, one valley R6", n_val, 1);
        chk("R7 no timeout", n_rst, 0);

        // low load: fall inside blanking, level changes late (R9)
        zero(); hi = 0; z = 1;
        strobe(); run(9); hi = 1; run(30); z = 0; run(560);
        chk("R9 clamp length stays low-load R3", n_hold, 35);
        chk("R2 fall in blanking gives no valley", n_val, 0);
        chk("R7 timeout after blanking", n_rst, 1);

        // late rising edge restarts the timer
        zero(); hi = 0; z = 0;
        strobe(); run(299); z = 1; run(300);
        chk("R7 timer re-armed by edge", n_rst, 0);
        run(200);
        chk("R7 timeout after last edge", n_rst, 1);

        // four consecutive shorts
        zero(); hi = 0; z = 1; sh = 1;
        for (int k = 0; k < 4; k++) begin strobe(); run(79); end
        chk("R4 fault after four shorts", n_flt, 1);
        chk("R8 watch aborted, no timeout", n_rst, 0);

        // run broken by a clean cycle
        zero();
        for (int k = 0; k < 3; k++) begin strobe(); run(79); end
        sh = 0; strobe(); run(79); sh = 1;
        for (int k = 0; k < 3; k++) begin strobe(); run(79); end
        chk("R5 clean cycle clears run", n_flt, 0);
        strobe(); run(79);
        chk("R4 fourth consecutive short", n_flt, 1);

        // strobe during pending valley delay
        zero(); sh = 0; hi = 0; z = 1;
        strobe(); run(149); z = 0; run(10); strobe(); run(100);
        chk("R8 pending valley aborted", n_val, 0);
        chk("R8 no restart yet", n_rst, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule